// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small processor core from normal execution into an exception handler. When an entry request is accepted, it saves the caller's register frame on the data-side write port. At the same time, it reads the handler address from the vector table on the instruction-side read port. When both are finished, it writes the new program counter and then the link register. It then raises a one-cycle completion flag. A pipeline refill request carrying the handler address goes out as soon as the vector word returns, so instruction fetch can start while stacking is still running.

A second request may arrive after the entry has begun. If it arrives while the vector word is still outstanding, the block aims the read at the new exception number, and the frame writes continue without being repeated. If it arrives later, the block holds it. Once the current entry completes, the held request starts its own entry as a tail-chained one. A tail-chained entry skips stacking entirely. A reset entry also skips stacking. Instead, it loads the main stack pointer from the first word of the table before it reads the handler address.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `dwr_valid`, `ird_valid`, `sp_we`, `pc_we`, `lr_we`, `refill_valid` and `done` are all low, and they stay low until a request is accepted.
- R2: An ordinary entry (neither reset nor tail-chained) issues exactly FRAME_WORDS word writes, one per accepted handshake. Write i goes to address S - 4*FRAME_WORDS + 4*i with data `frame_words[32*i +: 32]`, for i ascending from 0. S is `psp_in` when `in_handler` is 0 and `thread_on_psp` is 1; otherwise S is `msp_in`. A stalled write holds its address and data.
- R3: For an ordinary entry, `sp_we` pulses once, in the cycle after acceptance. It carries S - 4*FRAME_WORDS, and `sp_psp_sel` is 1 exactly when the process stack was selected.
- R4: The vector word is read at `table_base + 4*num` on the instruction port. This read is issued in the first busy cycle, while the frame writes are still in progress. A stalled read holds its address.
- R5: A `late_valid` pulse that arrives before the vector word has been accepted redirects the read to `table_base + 4*late_num`. Any word returning in that cycle is discarded, and the handler address becomes the word read from the new address. Frame writes already made are not reissued, so the total stays FRAME_WORDS.
- R6: A reset entry (`req_is_reset`=1) makes no frame writes and no link-register write. It first reads the word at `table_base` and loads it into the main stack pointer (`sp_we`=1, `sp_psp_sel`=0). It then reads the handler address at `table_base + 4*num`.
- R7: `pc_we` pulses exactly once per entry, for one cycle, after both the stacking and the vector read are complete. `pc_wdata` carries the vector word.
- R8: Except on reset entries, `lr_we` pulses in the cycle after `pc_we`. The value written depends on the state before entry: 0xFFFFFFF1 from handler mode, 0xFFFFFFF9 from thread mode on the main stack, and 0xFFFFFFFD from thread mode on the process stack.
- R9: A tail-chained entry (`tail_chain`=1) makes no frame writes and no stack-pointer write.
- R10: `refill_valid` pulses once per entry, in the cycle after the vector word is accepted, with `refill_addr` equal to that word. This happens before `pc_we`.
- R11: A `late_valid` pulse that arrives while busy but after the vector word has been accepted is held. After `done`, it begins a tail-chained entry for `late_num`, with no writes. That entry writes the same link-register value as the entry it followed.
- R12: `done` pulses for one cycle, in the cycle after the link-register step. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Entry request, sampled only while idle |
| req_num | input | NUM_W | Exception number of the request |
| req_is_reset | input | 1 | Request is a reset entry |
| tail_chain | input | 1 | Request follows a handler directly; skip stacking |
| late_valid | input | 1 | Late request while busy |
| late_num | input | NUM_W | Exception number of the late request |
| table_base | input | 32 | Vector table base address |
| frame_words | input | 32*FRAME_WORDS | Frame to save; slice i goes to offset 4*i |
| msp_in | input | 32 | Current main stack pointer |
| psp_in | input | 32 | Current process stack pointer |
| thread_on_psp | input | 1 | Thread mode uses the process stack |
| in_handler | input | 1 | Core is in handler mode before entry |
| dwr_valid | output | 1 | Data-side write valid |
| dwr_addr | output | 32 | Data-side write address |
| dwr_data | output | 32 | Data-side write data |
| dwr_ready | input | 1 | Data-side write accepted |
| ird_valid | output | 1 | Instruction-side read valid |
| ird_addr | output | 32 | Instruction-side read address |
| ird_ready | input | 1 | Read accepted; `ird_data` valid in the same cycle |
| ird_data | input | 32 | Read data |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_psp_sel | output | 1 | Stack pointer written is the process stack |
| sp_wdata | output | 32 | New stack pointer |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | Handler address |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | 32 | Exception return code |
| refill_valid | output | 1 | Pipeline refill request |
| refill_addr | output | 32 | Refill fetch address |
| busy | output | 1 | An entry is in progress |
| done | output | 1 | Entry complete |

## Verification
The bench uses the default parameters: NUM_W = 9 and FRAME_WORDS = 8. With nine-bit numbers, exception 511 is reachable, which puts the vector read at table offset 0x7FC, the furthest the adder must carry. Eight frame words wrap the write index counter through its full range, so the last-write decision is exercised. Random stalls on both ports, together with deliberate holds, let a late request land both inside and outside the redirect window.

// File: rtl/entry_pkg.sv
package entry_pkg;

  localparam int WORD_W = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STACK_FETCH,
    ST_UPD_PC,
    ST_UPD_LR,
    ST_DONE
  } entry_state_e;

  // Table slot address for an exception number.
  function automatic logic [WORD_W-1:0] vector_addr(input logic [WORD_W-1:0] base,
                                                     input logic [WORD_W-1:0] num);
    return base + (num << 2);
  endfunction

  // Lowest frame address once the frame has been reserved below sp.
  function automatic logic [WORD_W-1:0] frame_base(input logic [WORD_W-1:0] sp,
                                                    input int words);
    return sp - WORD_W'(words * WORD_BYTES);
  endfunction

  // Return code chosen from the pre-entry mode and stack.
  function automatic logic [WORD_W-1:0] exc_return_code(input logic from_handler,
                                                         input logic on_psp);
    if (from_handler) return 32'hFFFF_FFF1;
    if (on_psp)       return 32'hFFFF_FFFD;
    return 32'hFFFF_FFF9;
  endfunction

endpackage

// File: rtl/entry_stacker.sv
module entry_stacker
  import entry_pkg::*;
#(
  parameter int FRAME_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [WORD_W-1:0]             base,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame,
  output logic                          wr_valid,
  output logic [WORD_W-1:0]             wr_addr,
  output logic [WORD_W-1:0]             wr_data,
  input  logic                          wr_ready,
  output logic                          finished
);

  localparam int IDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  logic                          active_q;
  logic                          fin_q;
  logic [IDX_W-1:0]              idx_q;
  logic [WORD_W-1:0]             base_q;
  logic [FRAME_WORDS*WORD_W-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      frame_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      fin_q    <= 1'b0;
      idx_q    <= '0;
      base_q   <= base;
      frame_q  <= frame;
    end else if (active_q && wr_ready) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        fin_q    <= 1'b1;
      end
      idx_q <= idx_q + 1'b1;
    end
  end

  assign wr_valid = active_q;
  assign wr_addr  = base_q + (WORD_W'(idx_q) << 2);
  assign wr_data  = frame_q[int'(idx_q)*WORD_W +: WORD_W];
  assign finished = fin_q;

endmodule

// File: rtl/vector_fetcher.sv
module vector_fetcher
  import entry_pkg::*;
#(
  parameter int NUM_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              restart,
  input  logic              want_sp,
  input  logic [WORD_W-1:0] table_base,
  input  logic [NUM_W-1:0]  num,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_value,
  output logic              vec_ready,
  output logic              vec_new,
  output logic [WORD_W-1:0] vec_value
);

  logic              busy_q, sp_phase_q, done_q, sp_load_q, vec_new_q;
  logic [WORD_W-1:0] base_q, sp_val_q, vec_q;
  logic [NUM_W-1:0]  num_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      sp_phase_q <= 1'b0;
      done_q     <= 1'b0;
      sp_load_q  <= 1'b0;
      vec_new_q  <= 1'b0;
      base_q     <= '0;
      sp_val_q   <= '0;
      vec_q      <= '0;
      num_q      <= '0;
    end else begin
      sp_load_q <= 1'b0;
      vec_new_q <= 1'b0;
      if (start) begin
        busy_q     <= 1'b1;
        sp_phase_q <= want_sp;
        done_q     <= 1'b0;
        base_q     <= table_base;
        num_q      <= num;
      end else if (restart) begin
        busy_q     <= 1'b1;
        sp_phase_q <= 1'b0;
        done_q     <= 1'b0;
        num_q      <= num;
      end else if (busy_q && rd_ready) begin
        if (sp_phase_q) begin
          sp_phase_q <= 1'b0;
          sp_load_q  <= 1'b1;
          sp_val_q   <= rd_data;
        end else begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          vec_new_q <= 1'b1;
          vec_q     <= rd_data;
        end
      end
    end
  end

  assign rd_valid  = busy_q;
  assign rd_addr   = sp_phase_q ? base_q : vector_addr(base_q, WORD_W'(num_q));
  assign sp_load   = sp_load_q;
  assign sp_value  = sp_val_q;
  assign vec_ready = done_q;
  assign vec_new   = vec_new_q;
  assign vec_value = vec_q;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import entry_pkg::*;
#(
  parameter int NUM_W       = 9,
  parameter int FRAME_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [NUM_W-1:0]              req_num,
  input  logic                          req_is_reset,
  input  logic                          tail_chain,
  input  logic                          late_valid,
  input  logic [NUM_W-1:0]              late_num,
  input  logic [WORD_W-1:0]             table_base,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_words,
  input  logic [WORD_W-1:0]             msp_in,
  input  logic [WORD_W-1:0]             psp_in,
  input  logic                          thread_on_psp,
  input  logic                          in_handler,
  output logic                          dwr_valid,
  output logic [WORD_W-1:0]             dwr_addr,
  output logic [WORD_W-1:0]             dwr_data,
  input  logic                          dwr_ready,
  output logic                          ird_valid,
  output logic [WORD_W-1:0]             ird_addr,
  input  logic                          ird_ready,
  input  logic [WORD_W-1:0]             ird_data,
  output logic                          sp_we,
  output logic                          sp_psp_sel,
  output logic [WORD_W-1:0]             sp_wdata,
  output logic                          pc_we,
  output logic [WORD_W-1:0]             pc_wdata,
  output logic                          lr_we,
  output logic [WORD_W-1:0]             lr_wdata,
  output logic                          refill_valid,
  output logic [WORD_W-1:0]             refill_addr,
  output logic                          busy,
  output logic                          done
);

  entry_state_e      state_q;
  logic              reset_q, skip_q, psp_q, pend_q;
  logic              sp_push_we_q;
  logic [WORD_W-1:0] sp_push_val_q, lr_code_q;
  logic [NUM_W-1:0]  pend_num_q;

  // Named internal events, also observed by the checker.
  logic              take_evt, push_start, restart_evt, hold_evt, fetch_window;
  logic              push_fin, push_ok, vec_ready, vec_new, f_sp_load;
  logic              take_reset, take_skip, take_psp;
  logic [NUM_W-1:0]  take_num, fetch_num;
  logic [WORD_W-1:0] stack_sp, new_sp, vec_value, f_sp_value;

  assign take_evt     = (state_q == ST_IDLE) && (pend_q || req_valid);
  assign take_num     = pend_q ? pend_num_q : req_num;
  assign take_reset   = !pend_q && req_is_reset;
  assign take_skip    = pend_q || tail_chain || req_is_reset;
  assign take_psp     = !in_handler && thread_on_psp;
  assign stack_sp     = take_psp ? psp_in : msp_in;
  assign new_sp       = frame_base(stack_sp, FRAME_WORDS);
  assign push_start   = take_evt && !take_skip;
  assign fetch_window = (state_q == ST_STACK_FETCH) && !vec_ready && !reset_q;
  assign restart_evt  = fetch_window && late_valid;
  assign hold_evt     = late_valid && (state_q != ST_IDLE) && !fetch_window;
  assign fetch_num    = take_evt ? take_num : late_num;
  assign push_ok      = skip_q || push_fin;

  entry_stacker #(.FRAME_WORDS(FRAME_WORDS)) u_stacker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (push_start),
    .base     (new_sp),
    .frame    (frame_words),
    .wr_valid (dwr_valid),
    .wr_addr  (dwr_addr),
    .wr_data  (dwr_data),
    .wr_ready (dwr_ready),
    .finished (push_fin)
  );

  vector_fetcher #(.NUM_W(NUM_W)) u_fetcher (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take_evt),
    .restart    (restart_evt),
    .want_sp    (take_reset),
    .table_base (table_base),
    .num        (fetch_num),
    .rd_valid   (ird_valid),
    .rd_addr    (ird_addr),
    .rd_ready   (ird_ready),
    .rd_data    (ird_data),
    .sp_load    (f_sp_load),
    .sp_value   (f_sp_value),
    .vec_ready  (vec_ready),
    .vec_new    (vec_new),
    .vec_value  (vec_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      reset_q       <= 1'b0;
      skip_q        <= 1'b0;
      psp_q         <= 1'b0;
      pend_q        <= 1'b0;
      pend_num_q    <= '0;
      sp_push_we_q  <= 1'b0;
      sp_push_val_q <= '0;
      lr_code_q     <= '0;
    end else begin
      sp_push_we_q <= push_start;
      if (push_start) begin
        sp_push_val_q <= new_sp;
        psp_q         <= take_psp;
      end
      if (take_evt) begin
        reset_q <= take_reset;
        skip_q  <= take_skip;
        if (!pend_q) lr_code_q <= exc_return_code(in_handler, thread_on_psp);
      end
      if (take_evt && pend_q) begin
        pend_q <= 1'b0;
      end else if (hold_evt) begin
        pend_q     <= 1'b1;
        pend_num_q <= late_num;
      end
      case (state_q)
        ST_IDLE:        if (take_evt) state_q <= ST_STACK_FETCH;
        ST_STACK_FETCH: if (push_ok && vec_ready) state_q <= ST_UPD_PC;
        ST_UPD_PC:      state_q <= ST_UPD_LR;
        ST_UPD_LR:      state_q <= ST_DONE;
        ST_DONE:        state_q <= ST_IDLE;
        default:        state_q <= ST_IDLE;
      endcase
    end
  end

  assign sp_we        = sp_push_we_q || f_sp_load;
  assign sp_psp_sel   = sp_push_we_q && psp_q;
  assign sp_wdata     = sp_push_we_q ? sp_push_val_q : f_sp_value;
  assign pc_we        = (state_q == ST_UPD_PC);
  assign pc_wdata     = vec_value;
  assign lr_we        = (state_q == ST_UPD_LR) && !reset_q;
  assign lr_wdata     = lr_code_q;
  assign refill_valid = vec_new;
  assign refill_addr  = vec_value;
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        dwr_valid,
  input logic        dwr_ready,
  input logic [31:0] dwr_addr,
  input logic [31:0] dwr_data,
  input logic        ird_valid,
  input logic        ird_ready,
  input logic [31:0] ird_addr,
  input logic        restart_evt,
  input logic        pc_we,
  input logic        lr_we,
  input logic        refill_valid,
  input logic        done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dwr_valid && !ird_valid && !pc_we && !lr_we));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_valid && !dwr_ready) |=> (dwr_valid && $stable(dwr_addr) && $stable(dwr_data)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ird_valid && !ird_ready && !restart_evt) |=> (ird_valid && $stable(ird_addr)));

  // R7
  pc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> !pc_we);

  // R8
  lr_after_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we |-> $past(pc_we));

  // R10
  refill_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> (busy && !pc_we));

  // R12
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .dwr_valid    (dwr_valid),
  .dwr_ready    (dwr_ready),
  .dwr_addr     (dwr_addr),
  .dwr_data     (dwr_data),
  .ird_valid    (ird_valid),
  .ird_ready    (ird_ready),
  .ird_addr     (ird_addr),
  .restart_evt  (restart_evt),
  .pc_we        (pc_we),
  .lr_we        (lr_we),
  .refill_valid (refill_valid),
  .done         (done)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  localparam int NW = 9;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_is_reset = 0, tail_chain = 0, late_valid = 0;
  logic [NW-1:0] req_num = '0, late_num = '0;
  logic [31:0] table_base = 32'h0000_4000, msp_in = 32'h2000_1000, psp_in = 32'h2000_8000;
  logic [FW*32-1:0] frame_words;
  logic thread_on_psp = 0, in_handler = 0;
  logic dwr_valid, ird_valid, dwr_ready, ird_ready;
  logic [31:0] dwr_addr, dwr_data, ird_addr, ird_data;
  logic sp_we, sp_psp_sel, pc_we, lr_we, refill_valid, busy, done;
  logic [31:0] sp_wdata, pc_wdata, lr_wdata, refill_addr;

  always #10 clk = ~clk;

  function automatic logic [31:0] vec_of(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A00_0001;
  endfunction

  assign ird_data = vec_of(ird_addr);

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
    .req_is_reset(req_is_reset), .tail_chain(tail_chain), .late_valid(late_valid),
    .late_num(late_num), .table_base(table_base), .frame_words(frame_words),
    .msp_in(msp_in), .psp_in(psp_in), .thread_on_psp(thread_on_psp),
    .in_handler(in_handler), .dwr_valid(dwr_valid), .dwr_addr(dwr_addr),
    .dwr_data(dwr_data), .dwr_ready(dwr_ready), .ird_valid(ird_valid),
    .ird_addr(ird_addr), .ird_ready(ird_ready), .ird_data(ird_data),
    .sp_we(sp_we), .sp_psp_sel(sp_psp_sel), .sp_wdata(sp_wdata), .pc_we(pc_we),
    .pc_wdata(pc_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .busy(busy), .done(done)
  );

  int errors = 0, checks = 0;
  bit dwr_hold = 0, ird_hold = 0, jitter = 0;
  logic [7:0] lfsr = 8'hA7;

  // Reference expectations for the entry in flight.
  logic [31:0] wq_a[$], wq_d[$], rd_log[$];
  logic [31:0] exp_sp, exp_pc, exp_lr;
  logic exp_psp;
  int exp_sp_cnt, exp_lr_cnt;
  int sp_seen, pc_seen, lr_seen, refill_seen, done_seen, wr_seen;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock monitor: pick ready for the coming edge, then compare every event.
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dwr_ready = !dwr_hold && (!jitter || lfsr[0]);
    ird_ready = !ird_hold && (!jitter || lfsr[2]);
    if (rst_n) begin
      if (dwr_valid && dwr_ready) begin
        wr_seen++;
        if (wq_a.size() == 0) chk(0, "R9 unexpected write", dwr_addr, 32'h0);
        else begin
          chk(dwr_addr == wq_a[0], "R2 write addr", dwr_addr, wq_a[0]);
          chk(dwr_data == wq_d[0], "R2 write data", dwr_data, wq_d[0]);
          void'(wq_a.pop_front());
          void'(wq_d.pop_front());
        end
      end
      if (ird_valid && ird_ready) rd_log.push_back(ird_addr);
      if (sp_we) begin
        sp_seen++;
        chk(sp_wdata == exp_sp, "R3/R6 sp value", sp_wdata, exp_sp);
        chk(sp_psp_sel == exp_psp, "R3 sp select", 32'(sp_psp_sel), 32'(exp_psp));
      end
      if (refill_valid) begin
        refill_seen++;
        chk(refill_addr == exp_pc, "R10 refill addr", refill_addr, exp_pc);
        chk(pc_seen == 0, "R10 refill before pc", pc_seen, 0);
      end
      if (pc_we) begin
        pc_seen++;
        chk(pc_wdata == exp_pc, "R7 pc value", pc_wdata, exp_pc);
        chk(wq_a.size() == 0, "R7 pc after stacking", wq_a.size(), 0);
      end
      if (lr_we) begin
        lr_seen++;
        chk(lr_wdata == exp_lr, "R8 lr code", lr_wdata, exp_lr);
        chk(pc_seen == 1, "R8 lr after pc", pc_seen, 1);
      end
      if (done) begin
        done_seen++;
        chk(pc_seen == 1, "R12 done after pc", pc_seen, 1);
      end
    end
  end

  task automatic clear_seen();
    sp_seen = 0; pc_seen = 0; lr_seen = 0; refill_seen = 0; wr_seen = 0;
    rd_log.delete();
  endtask

  task automatic start_entry(input int num, input bit rst, input bit tc,
                             input bit hdl, input bit onpsp);
    logic [31:0] s, b;
    @(posedge clk); #1;
    wq_a.delete(); wq_d.delete(); clear_seen();
    s = (!hdl && onpsp) ? psp_in : msp_in;
    b = s - 32'(FW * 4);
    if (!rst && !tc)
      for (int i = 0; i < FW; i++) begin
        wq_a.push_back(b + 32'(4 * i));
        wq_d.push_back(frame_words[32*i +: 32]);
      end
    exp_sp_cnt = rst ? 1 : (tc ? 0 : 1);
    exp_sp     = rst ? vec_of(table_base) : b;
    exp_psp    = !rst && !hdl && onpsp;
    exp_pc     = vec_of(table_base + 32'(4 * num));
    exp_lr_cnt = rst ? 0 : 1;
    exp_lr     = hdl ? 32'hFFFF_FFF1 : (onpsp ? 32'hFFFF_FFFD : 32'hFFFF_FFF9);
    req_valid = 1; req_num = NW'(num); req_is_reset = rst; tail_chain = tc;
    in_handler = hdl; thread_on_psp = onpsp;
    @(posedge clk); #1;
    req_valid = 0; req_is_reset = 0; tail_chain = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_seen < target) @(posedge clk);
    #1;
  endtask

  task automatic end_checks(input string tag);
    chk(wq_a.size() == 0, {"R2/R9 writes left ", tag}, wq_a.size(), 0);
    chk(pc_seen == 1, {"R7 pc count ", tag}, pc_seen, 1);
    chk(lr_seen == exp_lr_cnt, {"R8 lr count ", tag}, lr_seen, exp_lr_cnt);
    chk(sp_seen == exp_sp_cnt, {"R3/R9 sp count ", tag}, sp_seen, exp_sp_cnt);
    chk(refill_seen == 1, {"R10 refill count ", tag}, refill_seen, 1);
    chk(!busy, {"R12 idle after done ", tag}, 32'(busy), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < FW; i++) frame_words[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 'h111);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk(!busy && !dwr_valid && !ird_valid, "R1 idle ports", {busy, dwr_valid, ird_valid}, 0);
    chk(!sp_we && !pc_we && !lr_we && !refill_valid && !done, "R1 idle strobes",
        {sp_we, pc_we, lr_we, refill_valid, done}, 0);

    // R2 R3 R4 R8: thread on main stack, no stalls
    start_entry(11, 0, 0, 0, 0);
    wait_done(1);
    end_checks("thread msp");
    chk(rd_log.size() == 1 && rd_log[0] == table_base + 44, "R4 vector addr", rd_log[0], table_base + 44);

    // R2 R3 R8: thread on process stack with random stalls
    jitter = 1;
    start_entry(23, 0, 0, 0, 1);
    wait_done(2);
    end_checks("thread psp");
    chk(wr_seen == FW, "R2 write count", wr_seen, FW);

    // R4 R8: handler mode, largest exception number
    start_entry(511, 0, 0, 1, 1);
    wait_done(3);
    end_checks("handler max num");
    chk(rd_log[0] == table_base + 32'h7FC, "R4 top slot", rd_log[0], table_base + 32'h7FC);
    jitter = 0;

    // R9 tail chain
    start_entry(40, 0, 1, 1, 0);
    wait_done(4);
    end_checks("tail chain");
    chk(wr_seen == 0, "R9 no writes", wr_seen, 0);

    // R6 reset entry
    start_entry(1, 1, 0, 0, 0);
    wait_done(5);
    end_checks("reset");
    chk(rd_log.size() == 2, "R6 read count", rd_log.size(), 2);
    chk(rd_log[0] == table_base, "R6 sp word addr", rd_log[0], table_base);
    chk(rd_log[1] == table_base + 4, "R6 vector addr", rd_log[1], table_base + 4);
    chk(wr_seen == 0, "R6 no writes", wr_seen, 0);

    // R5 late request inside the fetch window
    ird_hold = 1;
    start_entry(20, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    chk(ird_valid && ird_addr == table_base + 80, "R4 stalled read addr", ird_addr, table_base + 80);
    late_valid = 1; late_num = 37;
    exp_pc = vec_of(table_base + 148);
    @(posedge clk); #1;
    late_valid = 0;
    chk(ird_addr == table_base + 148, "R5 redirected addr", ird_addr, table_base + 148);
    ird_hold = 0;
    wait_done(6);
    end_checks("late redirect");
    chk(wr_seen == FW, "R5 writes not repeated", wr_seen, FW);

    // R11 late request after the vector: held, then tail-chained
    dwr_hold = 1;
    start_entry(5, 0, 0, 0, 1);
    while (refill_seen == 0) @(posedge clk);
    #1;
    late_valid = 1; late_num = 9;
    @(posedge clk); #1;
    late_valid = 0;
    chk(pc_wdata == exp_pc, "R11 vector kept", pc_wdata, exp_pc);
    dwr_hold = 0;
    wait_done(7);
    end_checks("before held");
    clear_seen();
    exp_sp_cnt = 0; exp_pc = vec_of(table_base + 36); exp_lr_cnt = 1;
    wait_done(8);
    end_checks("R11 held entry");
    chk(wr_seen == 0, "R11 held no writes", wr_seen, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d done pulses", done_seen, 8);
    finish_run();
  end

endmodule